// File: doc/BRIEF.md
# SPI Serial EEPROM Command Engine

This block is the slave-side protocol engine of a 64K x 8 serial EEPROM that sits on a four-wire SPI bus (clock, data in, data out, active-low select) plus an active-low pause input. The four pins are brought into a fast system clock through synchronizers. Clock edges are found in that domain: input bits are taken on the serial-clock rising edge, and the output bit changes on the falling edge. Both SPI mode 0 and mode 3 work without configuration.

Each transaction begins with an 8-bit command byte. A read or write command is followed by a 16-bit address, sent most significant bit first. Array reads go through a synchronous RAM port, one byte at a time, and the address steps on by itself. A status read returns the byte that the write sequencer supplies. Write-enable, write-disable, status-write and array-write commands become request pulses towards that sequencer. A command byte the engine does not know, or any command other than status read while the sequencer is busy, makes the engine deaf and silent until the next deselect. The pause input freezes the serial sequence at its current bit without discarding it.

Top module: `spi_ee_cmd_engine`

## Requirements
- R1: Command bytes decode with bit 3 ignored and bits 7..4 required to be zero; bits 2..0 select 110 write-enable request, 100 write-disable request, 101 status read, 001 status write, 011 array read, 010 array write. A write-enable or write-disable command gives one pulse on `wren_req` or `wrdi_req`.
- R2: All fields shift most significant bit first. An array read takes a 16-bit address and then drives the byte stored there on `so`, with `so_oe` high, one bit per serial clock starting at the falling edge after the last address bit.
- R3: During an array read the address steps by one after each byte and wraps from the top address to 0.
- R4: After a command byte that decodes to nothing, `so_oe` stays low and no read or write request is issued until select has gone high and low again. A following transaction behaves normally.
- R5: While `seq_busy` is high, every command other than status read is treated as undecodable. Status read returns all ones while busy and `seq_status` otherwise, and repeats for as long as clocks continue.
- R6: With `hold_n` low, asserted and released while the serial clock is low, serial clock edges and `si` are ignored and `so_oe` is low. The sequence resumes at the same bit once the pause ends.
- R7: While select is high, `so_oe` is low and the sequence is reset, so the next transaction starts at a command byte.
- R8: Array write presents each complete data byte with its address on `wr_byte_*`. Only the low 7 address bits count up, so the address wraps within a 128-byte page. `wr_commit` pulses on deselect only if at least one byte arrived and the transfer ended on a byte boundary.
- R9: Status write raises `wrsr_req` with `wrsr_data` on deselect only if exactly 8 data bits followed the command.
- R10: Mode 3, where the serial clock idles high, gives the same results as mode 0.
- R11: Data on `si` after the read address is ignored while read data shifts out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the bus master |
| si | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low chip select |
| hold_n | input | 1 | Active-low pause |
| so | output | 1 | Serial data out (low when not enabled) |
| so_oe | output | 1 | Output enable for the `so` pad driver |
| mem_rd_en | output | 1 | Array read strobe |
| mem_rd_addr | output | 16 | Array read address |
| mem_rd_data | input | 8 | Array data, valid the cycle after the strobe |
| seq_busy | input | 1 | Write sequencer internal cycle in progress |
| seq_status | input | 8 | Status byte supplied by the sequencer |
| wren_req | output | 1 | Write-enable request pulse |
| wrdi_req | output | 1 | Write-disable request pulse |
| wrsr_req | output | 1 | Status write request pulse |
| wrsr_data | output | 8 | Status byte to write |
| wr_byte_valid | output | 1 | Array write data byte pulse |
| wr_byte_addr | output | 16 | Address for that byte |
| wr_byte_data | output | 8 | Data byte |
| wr_commit | output | 1 | Array write may start (deselect on a byte boundary) |

## Verification
Every pin goes through two synchronizer flops, and edges are decided one register later. A new `so` bit or a request pulse therefore appears at most three system cycles after the serial edge or deselect that caused it. The bench holds each serial clock level for eight system cycles. It samples `so` and `so_oe` at the end of the low phase, just before the rising edge, as a master would. It reads the request pulse counters only after the select line has been high for sixteen cycles, so no result is read inside its settling window.

// File: rtl/spi_ee_pkg.sv
// Package: shared types and command decode for the serial EEPROM engine.
// Assumes: 8-bit command bytes, bit 3 is a don't-care.
package spi_ee_pkg;

    typedef enum logic [2:0] {
        S_CMD,        // collecting command byte
        S_ADDR,       // collecting 16-bit address
        S_RD_OUT,     // streaming array data
        S_ST_OUT,     // streaming status byte
        S_WR_DATA,    // collecting array write bytes
        S_SW_DATA,    // collecting status write byte
        S_SW_FULL,    // status byte complete, waiting for deselect
        S_IGNORE      // deaf until deselect (done or locked out)
    } eng_state_t;

    typedef enum logic [2:0] {
        K_NONE, K_WEN, K_WDIS, K_STRD, K_STWR, K_READ, K_WRITE
    } cmd_kind_t;

    // Map a received command byte to its kind; unknown gives K_NONE.
    function automatic cmd_kind_t decode_cmd(input logic [7:0] b);
        cmd_kind_t k;
        k = K_NONE;
        if (b[7:4] == 4'h0) begin
            case (b[2:0])
                3'b110:  k = K_WEN;
                3'b100:  k = K_WDIS;
                3'b101:  k = K_STRD;
                3'b001:  k = K_STWR;
                3'b011:  k = K_READ;
                3'b010:  k = K_WRITE;
                default: k = K_NONE;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/spi_ee_pin_sync.sv
// Module: brings the serial pins into the system clock and finds edges.
// Assumes: clk is at least 8x the serial clock; pause changes only while
// the serial clock is low. Edges are suppressed while deselected or paused.
module spi_ee_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic si,
    input  logic cs_n,
    input  logic hold_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s,
    output logic cs_hi,
    output logic cs_rise,
    output logic hold_act
);
    localparam int          NPIN     = 4;
    localparam logic [NPIN-1:0] IDLE_LVL = 4'b0011; // {sck, si, cs_n, hold_n}

    logic [STAGES-1:0][NPIN-1:0] chain;
    logic sck_s, hold_s, sck_p, cs_p;

    // Synchronizer chain for all four pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= IDLE_LVL;
        end else begin
            chain[0] <= {sck, si, cs_n, hold_n};
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign sck_s  = chain[STAGES-1][3];
    assign si_s   = chain[STAGES-1][2];
    assign cs_hi  = chain[STAGES-1][1];
    assign hold_s = chain[STAGES-1][0];

    // Previous levels for edge detection; pause state changes only with sck low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_p    <= 1'b0;
            cs_p     <= 1'b1;
            hold_act <= 1'b0;
        end else begin
            sck_p <= sck_s;
            cs_p  <= cs_hi;
            if (!sck_s) hold_act <= !hold_s;
        end
    end

    assign sck_rise = sck_s & ~sck_p & ~hold_act & ~cs_hi;
    assign sck_fall = ~sck_s & sck_p & ~hold_act & ~cs_hi;
    assign cs_rise  = cs_hi & ~cs_p;

endmodule

// File: rtl/spi_ee_so_shift.sv
// Module: output shifter; loads a byte on the first falling edge of each
// byte slot and shifts MSB first on the following ones.
// Assumes: load_data is settled before the falling edge that takes it.
module spi_ee_so_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         run,
    input  logic         fall,
    input  logic [W-1:0] load_data,
    output logic         so_bit,
    output logic         live,
    output logic         taken
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  sreg;
    logic [CW-1:0] ocnt;

    assign taken  = run & fall & (ocnt == '0);
    assign so_bit = sreg[W-1];

    // Shift register and bit slot counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sreg <= '0;
            ocnt <= '0;
            live <= 1'b0;
        end else if (run && fall) begin
            if (ocnt == '0) begin
                sreg <= load_data;
                live <= 1'b1;
            end else begin
                sreg <= {sreg[W-2:0], 1'b0};
            end
            ocnt <= (ocnt == CW'(W-1)) ? '0 : ocnt + 1'b1;
        end
    end

endmodule

// File: rtl/spi_ee_cmd_engine.sv
// Module: top of the serial EEPROM command engine. Decodes the command,
// gathers address and data, streams array or status bytes, and raises
// request pulses for the write sequencer.
// Assumes: synchronous RAM (data one cycle after strobe); sequencer owns
// write-enable and protection policy.
module spi_ee_cmd_engine
    import spi_ee_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PAGE_BITS   = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              si,
    input  logic              cs_n,
    input  logic              hold_n,
    output logic              so,
    output logic              so_oe,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    input  logic              seq_busy,
    input  logic [7:0]        seq_status,
    output logic              wren_req,
    output logic              wrdi_req,
    output logic              wrsr_req,
    output logic [7:0]        wrsr_data,
    output logic              wr_byte_valid,
    output logic [ADDR_W-1:0] wr_byte_addr,
    output logic [7:0]        wr_byte_data,
    output logic              wr_commit
);
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(ADDR_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] LAST_ABIT = CNT_W'(ADDR_W - 1);

    logic sck_rise, sck_fall, si_s, cs_hi, cs_rise, hold_act;
    eng_state_t state;
    cmd_kind_t  kind, dec;
    logic [ADDR_W-1:0] sh_in, rd_next, wr_addr, addr_in;
    logic [CNT_W-1:0]  bitcnt;
    logic [7:0]        byte_in, obuf;
    logic rd_pend, got_byte, so_bit, out_live, taken, out_run;

    spi_ee_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .cs_n(cs_n),
        .hold_n(hold_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .si_s(si_s), .cs_hi(cs_hi), .cs_rise(cs_rise), .hold_act(hold_act)
    );

    assign out_run = (state == S_RD_OUT) || (state == S_ST_OUT);

    spi_ee_so_shift #(.W(BYTE_W)) u_out (
        .clk(clk), .rst_n(rst_n), .clear(cs_hi), .run(out_run),
        .fall(sck_fall), .load_data(obuf), .so_bit(so_bit),
        .live(out_live), .taken(taken)
    );

    assign byte_in = {sh_in[BYTE_W-2:0], si_s};
    assign addr_in = {sh_in[ADDR_W-2:0], si_s};
    assign dec     = decode_cmd(byte_in);
    assign so_oe   = out_live & out_run & ~cs_hi & ~hold_act;
    assign so      = so_bit & so_oe;

    // Main sequence: command, address, data phases and request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_CMD;  kind <= K_NONE;  bitcnt <= '0;  sh_in <= '0;
            rd_next <= '0;  wr_addr <= '0;  got_byte <= 1'b0;
            mem_rd_en <= 1'b0;  mem_rd_addr <= '0;
            wren_req <= 1'b0;  wrdi_req <= 1'b0;  wrsr_req <= 1'b0;
            wrsr_data <= '0;  wr_byte_valid <= 1'b0;  wr_byte_addr <= '0;
            wr_byte_data <= '0;  wr_commit <= 1'b0;
        end else begin
            mem_rd_en <= 1'b0;  wren_req <= 1'b0;  wrdi_req <= 1'b0;
            wrsr_req <= 1'b0;  wr_byte_valid <= 1'b0;  wr_commit <= 1'b0;
            if (cs_hi) begin
                wr_commit <= cs_rise && state == S_WR_DATA && got_byte && bitcnt == '0;
                wrsr_req  <= cs_rise && state == S_SW_FULL;
                state <= S_CMD;  bitcnt <= '0;  got_byte <= 1'b0;
            end else if (sck_rise) begin
                sh_in  <= addr_in;
                bitcnt <= bitcnt + 1'b1;
                case (state)
                    S_CMD: if (bitcnt == LAST_BIT) begin
                        bitcnt <= '0;
                        kind   <= dec;
                        if (seq_busy && dec != K_STRD) state <= S_IGNORE;
                        else case (dec)
                            K_WEN:   begin wren_req <= 1'b1; state <= S_IGNORE; end
                            K_WDIS:  begin wrdi_req <= 1'b1; state <= S_IGNORE; end
                            K_STRD:  state <= S_ST_OUT;
                            K_STWR:  state <= S_SW_DATA;
                            K_READ,
                            K_WRITE: state <= S_ADDR;
                            default: state <= S_IGNORE;
                        endcase
                    end
                    S_ADDR: if (bitcnt == LAST_ABIT) begin
                        bitcnt <= '0;
                        if (kind == K_READ) begin
                            mem_rd_en   <= 1'b1;
                            mem_rd_addr <= addr_in;
                            rd_next     <= addr_in + 1'b1;
                            state       <= S_RD_OUT;
                        end else begin
                            wr_addr <= addr_in;
                            state   <= S_WR_DATA;
                        end
                    end
                    S_WR_DATA: if (bitcnt == LAST_BIT) begin
                        bitcnt        <= '0;
                        got_byte      <= 1'b1;
                        wr_byte_valid <= 1'b1;
                        wr_byte_addr  <= wr_addr;
                        wr_byte_data  <= byte_in;
                        wr_addr[PAGE_BITS-1:0] <= wr_addr[PAGE_BITS-1:0] + 1'b1;
                    end
                    S_SW_DATA: if (bitcnt == LAST_BIT) begin
                        bitcnt    <= '0;
                        wrsr_data <= byte_in;
                        state     <= S_SW_FULL;
                    end
                    S_SW_FULL: state <= S_IGNORE;
                    default: bitcnt <= bitcnt;
                endcase
            end else if (taken && state == S_RD_OUT) begin
                mem_rd_en   <= 1'b1;
                mem_rd_addr <= rd_next;
                rd_next     <= rd_next + 1'b1;
            end
        end
    end

    // Output byte buffer: RAM data one cycle after the strobe, or live status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            obuf    <= '0;
        end else begin
            rd_pend <= mem_rd_en;
            if (state == S_ST_OUT) obuf <= seq_busy ? 8'hFF : seq_status;
            else if (rd_pend)      obuf <= mem_rd_data;
        end
    end

    // R6: a pause freezes the sequence position.
    a_r6_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_act && !cs_hi) |=> ($stable(bitcnt) && $stable(state)))
        else $error("R6 sequence moved while paused");

    // R4: a deaf transaction issues neither reads nor write bytes.
    a_r4_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IGNORE && !cs_hi) |=> (!mem_rd_en && !wr_byte_valid && !so_oe))
        else $error("R4 activity while locked out");

    // R1: at most one request pulse in any cycle.
    a_r1_req_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wren_req, wrdi_req, wrsr_req, wr_commit, wr_byte_valid, mem_rd_en}))
        else $error("R1 overlapping requests");

    // R8: commit only after an array write that ended on a byte boundary.
    a_r8_commit_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> ($past(state) == S_WR_DATA && $past(bitcnt) == '0 && $past(got_byte)))
        else $error("R8 commit off a byte boundary");

    // R7: deselect silences the output.
    a_r7_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_hi) |=> !so_oe)
        else $error("R7 output enabled after deselect");

endmodule

// File: tb/spi_ee_cmd_engine_bench.sv
module spi_ee_cmd_engine_bench;
    localparam int HALF = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, si = 1'b0, cs_n = 1'b1, hold_n = 1'b1;
    logic so, so_oe, mem_rd_en, seq_busy = 1'b0;
    logic [15:0] mem_rd_addr, wr_byte_addr;
    logic [7:0]  mem_rd_data = '0, seq_status = 8'h00, wrsr_data, wr_byte_data;
    logic wren_req, wrdi_req, wrsr_req, wr_byte_valid, wr_commit;

    int checks = 0, failures = 0;
    int n_wren = 0, n_wrdi = 0, n_wrsr = 0, n_wb = 0, n_commit = 0, n_rd = 0;
    int oe_hits = 0;
    logic [15:0] wlog_a [8];
    logic [7:0]  wlog_d [8];
    logic mode3 = 1'b0;

    always #10 clk = ~clk;

    spi_ee_cmd_engine u_spi_ee_cmd_engine (
        .clk(clk), .rst_n(rst_n), .sck(sck), .si(si), .cs_n(cs_n), .hold_n(hold_n),
        .so(so), .so_oe(so_oe), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .seq_busy(seq_busy), .seq_status(seq_status),
        .wren_req(wren_req), .wrdi_req(wrdi_req), .wrsr_req(wrsr_req),
        .wrsr_data(wrsr_data), .wr_byte_valid(wr_byte_valid),
        .wr_byte_addr(wr_byte_addr), .wr_byte_data(wr_byte_data), .wr_commit(wr_commit)
    );

    function automatic logic [7:0] patt(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // Synchronous RAM model and request monitors.
    always @(posedge clk) begin
        if (mem_rd_en) begin mem_rd_data <= patt(mem_rd_addr); n_rd <= n_rd + 1; end
        if (wren_req) n_wren <= n_wren + 1;
        if (wrdi_req) n_wrdi <= n_wrdi + 1;
        if (wrsr_req) n_wrsr <= n_wrsr + 1;
        if (wr_commit) n_commit <= n_commit + 1;
        if (wr_byte_valid) begin
            if (n_wb < 8) begin wlog_a[n_wb] <= wr_byte_addr; wlog_d[n_wb] <= wr_byte_data; end
            n_wb <= n_wb + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_half(); repeat (HALF) @(negedge clk); endtask

    task automatic spi_begin(input logic m3);
        mode3 = m3; sck = m3; wait_half(); cs_n = 1'b0; wait_half();
    endtask

    task automatic spi_end();
        sck = mode3; wait_half(); cs_n = 1'b1; wait_half(); wait_half();
    endtask

    task automatic spi_bit(input logic b, output logic r);
        sck = 1'b0; si = b; wait_half();
        r = so; if (so_oe) oe_hits++;
        sck = 1'b1; wait_half();
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin logic r; spi_bit(tx[i], r); rx[i] = r; end
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int n);
        for (int i = n - 1; i >= 0; i--) begin logic r; spi_bit(tx[i], r); end
    endtask

    // Pause with sck low, toggle sck with noise, resume with sck low.
    task automatic hold_pause(input int n);
        sck = 1'b0; wait_half(); hold_n = 1'b0; wait_half();
        chk(so_oe == 1'b0, "R6 so_oe during pause", so_oe, 0);
        for (int i = 0; i < n; i++) begin
            sck = 1'b1; si = i[0]; wait_half(); sck = 1'b0; wait_half();
        end
        chk(so_oe == 1'b0, "R6 so_oe after toggles in pause", so_oe, 0);
        hold_n = 1'b1; wait_half();
    endtask

    task automatic t_reset();
        chk(so_oe == 1'b0, "R7 reset so_oe", so_oe, 0);
        chk(n_wren + n_wrdi + n_wrsr + n_wb + n_commit + n_rd == 0, "R7 reset no requests",
            n_wren + n_wrdi + n_wrsr + n_wb + n_commit + n_rd, 0);
    endtask

    task automatic t_read_basic();
        logic [7:0] rx;
        int h0;
        spi_begin(1'b0);
        spi_byte(8'h03, rx); spi_byte(8'h12, rx); spi_byte(8'h34, rx);
        h0 = oe_hits;
        chk(h0 == 0, "R2 so_oe off during header", h0, 0);
        for (int k = 0; k < 3; k++) begin
            spi_byte((k == 1) ? 8'hFF : 8'hA5, rx);
            chk(rx == patt(16'h1234 + 16'(k)), "R2 R3 R11 read data", rx, patt(16'h1234 + 16'(k)));
        end
        chk(oe_hits - h0 == 24, "R2 so_oe during data", oe_hits - h0, 24);
        spi_end();
    endtask

    task automatic t_read_wrap_mode3();
        logic [7:0] rx;
        spi_begin(1'b1);
        spi_byte(8'h0B, rx); spi_byte(8'hFF, rx); spi_byte(8'hFF, rx);
        spi_byte(8'h00, rx);
        chk(rx == patt(16'hFFFF), "R10 R1 mode3 read top", rx, patt(16'hFFFF));
        spi_byte(8'h00, rx);
        chk(rx == patt(16'h0000), "R3 wrap to zero", rx, patt(16'h0000));
        spi_end();
    endtask

    task automatic t_wen_wdis();
        logic [7:0] rx;
        int a = n_wren, b = n_wrdi;
        spi_begin(1'b0); spi_byte(8'h06, rx); spi_end();
        chk(n_wren == a + 1, "R1 write-enable pulse", n_wren, a + 1);
        spi_begin(1'b1); spi_byte(8'h0C, rx); spi_end();
        chk(n_wrdi == b + 1, "R1 write-disable pulse bit3 set", n_wrdi, b + 1);
    endtask

    task automatic t_invalid();
        logic [7:0] rx;
        int h0 = oe_hits, r0 = n_rd, w0 = n_wb, e0 = n_wren;
        spi_begin(1'b0);
        spi_byte(8'h13, rx); spi_byte(8'h03, rx); spi_byte(8'h00, rx); spi_byte(8'h06, rx);
        spi_end();
        spi_begin(1'b0);
        spi_byte(8'h07, rx); spi_byte(8'h03, rx); spi_byte(8'h00, rx); spi_byte(8'h00, rx);
        spi_end();
        chk(oe_hits == h0, "R4 so_oe stays off", oe_hits - h0, 0);
        chk(n_rd == r0 && n_wb == w0 && n_wren == e0, "R4 no requests", n_rd - r0, 0);
        spi_begin(1'b0);
        spi_byte(8'h03, rx); spi_byte(8'h00, rx); spi_byte(8'h40, rx); spi_byte(8'h00, rx);
        spi_end();
        chk(rx == patt(16'h0040), "R4 next transaction normal", rx, patt(16'h0040));
    endtask

    task automatic t_busy();
        logic [7:0] rx;
        int e0 = n_wren, w0 = n_wb;
        seq_busy = 1'b1;
        spi_begin(1'b0); spi_byte(8'h06, rx); spi_end();
        spi_begin(1'b0); spi_byte(8'h02, rx); spi_byte(8'h00, rx); spi_byte(8'h00, rx);
        spi_byte(8'h99, rx); spi_end();
        chk(n_wren == e0 && n_wb == w0, "R5 busy blocks commands", n_wren - e0, 0);
        spi_begin(1'b0); spi_byte(8'h05, rx); spi_byte(8'h00, rx); spi_end();
        chk(rx == 8'hFF, "R5 status while busy", rx, 8'hFF);
        seq_busy = 1'b0; seq_status = 8'h8C;
        spi_begin(1'b1); spi_byte(8'h05, rx); spi_byte(8'h00, rx);
        chk(rx == 8'h8C, "R5 status idle", rx, 8'h8C);
        spi_byte(8'h00, rx);
        chk(rx == 8'h8C, "R5 status repeats", rx, 8'h8C);
        spi_end();
    endtask

    task automatic t_hold();
        logic [7:0] rx;
        spi_begin(1'b0);
        spi_byte(8'h03, rx); spi_byte(8'h20, rx);
        hold_pause(3);
        spi_byte(8'h40, rx); spi_byte(8'h00, rx);
        chk(rx == patt(16'h2040), "R6 data after pause in address", rx, patt(16'h2040));
        hold_pause(2);
        spi_byte(8'h00, rx);
        chk(rx == patt(16'h2041), "R6 data after pause in output", rx, patt(16'h2041));
        spi_end();
    endtask

    task automatic t_write();
        logic [7:0] rx;
        int w0 = n_wb, c0 = n_commit;
        spi_begin(1'b0);
        spi_byte(8'h02, rx); spi_byte(8'h10, rx); spi_byte(8'h7E, rx);
        spi_byte(8'h11, rx); spi_byte(8'h22, rx); spi_byte(8'h33, rx);
        spi_end();
        chk(n_wb == w0 + 3, "R8 three bytes", n_wb - w0, 3);
        chk(wlog_a[w0] == 16'h107E && wlog_d[w0] == 8'h11, "R8 first byte", wlog_a[w0], 16'h107E);
        chk(wlog_a[w0+1] == 16'h107F && wlog_d[w0+1] == 8'h22, "R8 second byte", wlog_a[w0+1], 16'h107F);
        chk(wlog_a[w0+2] == 16'h1000 && wlog_d[w0+2] == 8'h33, "R8 page wrap", wlog_a[w0+2], 16'h1000);
        chk(n_commit == c0 + 1, "R8 commit on boundary", n_commit - c0, 1);
        w0 = n_wb; c0 = n_commit;
        spi_begin(1'b1);
        spi_byte(8'h0A, rx); spi_byte(8'h00, rx); spi_byte(8'h05, rx);
        spi_byte(8'h77, rx); spi_bits(8'h05, 3);
        spi_end();
        chk(n_wb == w0 + 1 && wlog_d[w0] == 8'h77 && wlog_a[w0] == 16'h0005,
            "R8 partial byte logged", wlog_a[w0], 16'h0005);
        chk(n_commit == c0, "R8 no commit off boundary", n_commit - c0, 0);
    endtask

    task automatic t_wrsr();
        logic [7:0] rx;
        int s0 = n_wrsr;
        spi_begin(1'b0); spi_byte(8'h01, rx); spi_byte(8'h8C, rx); spi_end();
        chk(n_wrsr == s0 + 1 && wrsr_data == 8'h8C, "R9 status write", wrsr_data, 8'h8C);
        spi_begin(1'b0); spi_byte(8'h09, rx); spi_byte(8'h55, rx); spi_bits(8'h01, 1); spi_end();
        chk(n_wrsr == s0 + 1, "R9 nine bits rejected", n_wrsr - s0, 1);
    endtask

    task automatic t_deselect();
        logic [7:0] rx;
        spi_begin(1'b0);
        spi_byte(8'h03, rx); spi_byte(8'h01, rx); spi_byte(8'h00, rx); spi_bits(8'h00, 4);
        spi_end();
        chk(so_oe == 1'b0, "R7 so_oe off after deselect", so_oe, 0);
        spi_begin(1'b0);
        spi_byte(8'h03, rx); spi_byte(8'h01, rx); spi_byte(8'h00, rx); spi_byte(8'h00, rx);
        spi_end();
        chk(rx == patt(16'h0100), "R7 fresh sequence", rx, patt(16'h0100));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_read_basic();
        t_read_wrap_mode3();
        t_wen_wdis();
        t_invalid();
        t_busy();
        t_hold();
        t_write();
        t_wrsr();
        t_deselect();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule